// File: doc/BRIEF.md
# Memory-Stage Bus Error Trap Sequencer

This block turns a bus error that arrives during a load/store data phase into a precise exception in the last stage of a three-stage pipeline. The error belongs to the memory-stage instruction, which was issued a stage earlier. The bus reports it with a two-cycle error response.

On the first cycle of that response the block only registers the error. It also records whether the access was a load or a store, the instruction's PC and the data address. From the next cycle onward, the registered flag drives a trap request to the pipeline's redirect logic, in the same way as a mispredict flush taken from stage 3. The same flag kills whatever side-effecting instruction sits in stage 2, so that a younger load or store already in its address phase never reaches memory.

The request stays up until the redirect logic acknowledges it. The flag then clears, so each error response produces exactly one trap. A stalled data phase, a data phase that completes without error and an error seen with no memory operation in stage 3 all leave the block idle. Computing the trap vector and updating the status registers are left to the surrounding logic.

Top module: `lsu_buserr_trap`

## Requirements
- R1: After reset, trap_req and x_suppress are 0.
- R2: In the first cycle of an error response (m_valid=1, dph_err=1, dph_ready=0), trap_req stays 0 in that same cycle.
- R3: In the cycle after a first error cycle, trap_req is 1.
- R4: While trap_req is 1, trap_cause is 5 if the faulting operation was a load (m_is_store=0 in the first error cycle) and 7 if it was a store or atomic (m_is_store=1).
- R5: While trap_req is 1, trap_pc and trap_addr equal the m_pc and m_addr presented in the first error cycle.
- R6: A data phase stall (dph_ready=0, dph_err=0) of any length never raises trap_req.
- R7: A data phase that completes without error (dph_ready=1, dph_err=0) never raises trap_req.
- R8: An error response seen while m_valid=0 is ignored, and trap_req stays 0. A second error cycle (dph_ready=1, dph_err=1) with no pending flag also leaves trap_req at 0.
- R9: trap_req stays 1 until a cycle with trap_ack=1, and it is 0 from the following cycle, so each error response yields exactly one trap.
- R10: x_suppress is 1 exactly when trap_req=1, x_valid=1 and x_side_effect=1.
- R11: While a trap is pending, a further first-error cycle does not change trap_cause, trap_pc or trap_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | 1 | Stage 3 holds a load/store in its data phase |
| m_is_store | input | 1 | Stage 3 operation is a store or atomic (0 means load) |
| m_pc | input | PC_W | PC of the stage 3 instruction |
| m_addr | input | ADDR_W | Data address of the stage 3 access |
| dph_ready | input | 1 | Data phase ready from the bus |
| dph_err | input | 1 | Data phase error response from the bus |
| x_valid | input | 1 | Stage 2 holds a valid instruction |
| x_side_effect | input | 1 | Stage 2 instruction has side effects (memory access, register-file or status write) |
| trap_ack | input | 1 | Redirect logic accepts the trap request |
| trap_req | output | 1 | Exception redirect request from stage 3 |
| trap_cause | output | 4 | Exception cause code (5 load fault, 7 store fault) |
| trap_pc | output | PC_W | PC of the faulting instruction |
| trap_addr | output | ADDR_W | Address of the faulting access |
| x_suppress | output | 1 | Kill the side effects of the stage 2 instruction |

## Verification
The hardest case to reach from the ports is a second error response that arrives while an earlier trap is still waiting for its acknowledge, because the pipeline would normally flush before it. The bench holds trap_ack low and then drives a fresh first-error cycle with a different PC, address and operation type, and confirms that the captured values do not move. A bare second error cycle with no preceding first cycle, and a long stall before an error, are driven as separate directed scenarios.

// File: rtl/lsu_buserr_pkg.sv
package lsu_buserr_pkg;
    localparam int unsigned CAUSE_W = 4;
    typedef logic [CAUSE_W-1:0] cause_t;
    localparam cause_t CAUSE_LOAD_FAULT  = cause_t'(5);
    localparam cause_t CAUSE_STORE_FAULT = cause_t'(7);
endpackage

// File: rtl/lsu_buserr_capture.sv
module lsu_buserr_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_valid,
    input  logic              m_is_store,
    input  logic [PC_W-1:0]   m_pc,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              dph_ready,
    input  logic              dph_err,
    input  logic              trap_ack,
    output logic              flag_o,
    output logic              is_store_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              flag;
        logic              is_store;
        logic [PC_W-1:0]   pc;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic first_err;

    always_comb begin
        // first cycle of a two-cycle error response, owned by stage 3
        first_err = m_valid & dph_err & ~dph_ready;
        cap_d     = cap_q;
        if (cap_q.flag) begin
            if (trap_ack) begin
                cap_d.flag = 1'b0;
            end
        end else if (first_err) begin
            cap_d.flag     = 1'b1;
            cap_d.is_store = m_is_store;
            cap_d.pc       = m_pc;
            cap_d.addr     = m_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign flag_o     = cap_q.flag;
    assign is_store_o = cap_q.is_store;
    assign pc_o       = cap_q.pc;
    assign addr_o     = cap_q.addr;
endmodule

// File: rtl/lsu_buserr_report.sv
module lsu_buserr_report
    import lsu_buserr_pkg::*;
(
    input  logic   flag_i,
    input  logic   is_store_i,
    input  logic   x_valid,
    input  logic   x_side_effect,
    output logic   trap_req,
    output cause_t trap_cause,
    output logic   x_suppress
);
    always_comb begin
        trap_req   = flag_i;
        trap_cause = '0;
        if (flag_i) begin
            trap_cause = is_store_i ? CAUSE_STORE_FAULT : CAUSE_LOAD_FAULT;
        end
        // flush from stage 3 kills any side effect of the younger instruction
        x_suppress = flag_i & x_valid & x_side_effect;
    end
endmodule

// File: rtl/lsu_buserr_trap.sv
module lsu_buserr_trap
    import lsu_buserr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_valid,
    input  logic              m_is_store,
    input  logic [PC_W-1:0]   m_pc,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              dph_ready,
    input  logic              dph_err,
    input  logic              x_valid,
    input  logic              x_side_effect,
    input  logic              trap_ack,
    output logic              trap_req,
    output logic [3:0]        trap_cause,
    output logic [PC_W-1:0]   trap_pc,
    output logic [ADDR_W-1:0] trap_addr,
    output logic              x_suppress
);
    logic   flag;
    logic   is_store;
    cause_t cause;

    lsu_buserr_capture #(
        .ADDR_W (ADDR_W),
        .PC_W   (PC_W)
    ) capture_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_valid    (m_valid),
        .m_is_store (m_is_store),
        .m_pc       (m_pc),
        .m_addr     (m_addr),
        .dph_ready  (dph_ready),
        .dph_err    (dph_err),
        .trap_ack   (trap_ack),
        .flag_o     (flag),
        .is_store_o (is_store),
        .pc_o       (trap_pc),
        .addr_o     (trap_addr)
    );

    lsu_buserr_report report_i (
        .flag_i        (flag),
        .is_store_i    (is_store),
        .x_valid       (x_valid),
        .x_side_effect (x_side_effect),
        .trap_req      (trap_req),
        .trap_cause    (cause),
        .x_suppress    (x_suppress)
    );

    assign trap_cause = 4'(cause);
endmodule

// File: rtl/lsu_buserr_trap_chk.sv
module lsu_buserr_trap_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PC_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_is_store,
    input logic [PC_W-1:0]   m_pc,
    input logic [ADDR_W-1:0] m_addr,
    input logic              dph_ready,
    input logic              dph_err,
    input logic              x_valid,
    input logic              x_side_effect,
    input logic              trap_ack,
    input logic              trap_req,
    input logic [3:0]        trap_cause,
    input logic [PC_W-1:0]   trap_pc,
    input logic [ADDR_W-1:0] trap_addr,
    input logic              x_suppress
);
    logic first_err;
    assign first_err = m_valid & dph_err & ~dph_ready;

    p_raise_after_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_err && !trap_req) |=> trap_req);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_err && !trap_req) |=> (trap_pc == $past(m_pc)) && (trap_addr == $past(m_addr))
            && (trap_cause == ($past(m_is_store) ? 4'd7 : 4'd5)));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !first_err) |=> !trap_req);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> trap_req && $stable(trap_pc) && $stable(trap_addr)
            && $stable(trap_cause));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_ack) |=> !trap_req);

    p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_cause == 4'd5 || trap_cause == 4'd7));

    p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        x_suppress == (trap_req && x_valid && x_side_effect));
endmodule

bind lsu_buserr_trap lsu_buserr_trap_chk #(
    .ADDR_W (ADDR_W),
    .PC_W   (PC_W)
) chk_i (.*);

// File: tb/lsu_buserr_trap_tb_top.sv
module lsu_buserr_trap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0, m_is_store = 1'b0;
    logic [31:0] m_pc = '0, m_addr = '0;
    logic        dph_ready = 1'b1, dph_err = 1'b0;
    logic        x_valid = 1'b0, x_side_effect = 1'b0, trap_ack = 1'b0;
    logic        trap_req, x_suppress;
    logic [3:0]  trap_cause;
    logic [31:0] trap_pc, trap_addr;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    lsu_buserr_trap dut_i (
        .clk (clk), .rst_n (rst_n),
        .m_valid (m_valid), .m_is_store (m_is_store), .m_pc (m_pc), .m_addr (m_addr),
        .dph_ready (dph_ready), .dph_err (dph_err),
        .x_valid (x_valid), .x_side_effect (x_side_effect), .trap_ack (trap_ack),
        .trap_req (trap_req), .trap_cause (trap_cause), .trap_pc (trap_pc),
        .trap_addr (trap_addr), .x_suppress (x_suppress)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            $display("FAIL watchdog: act=%0d cycles exp=<5000", cyc);
            bad = bad + 1;
            total = total + 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // advance to the next negedge and leave the bus idle
    task automatic idle();
        @(negedge clk);
        m_valid = 1'b0; dph_ready = 1'b1; dph_err = 1'b0; trap_ack = 1'b0;
        x_valid = 1'b0; x_side_effect = 1'b0;
        #1;
    endtask

    task automatic first_err_cycle(input logic st, input logic [31:0] pc, input logic [31:0] ad);
        @(negedge clk);
        m_valid = 1'b1; m_is_store = st; m_pc = pc; m_addr = ad;
        dph_ready = 1'b0; dph_err = 1'b1; trap_ack = 1'b0;
        #1;
    endtask

    task automatic test_reset();
        chk(trap_req == 1'b0, "R1 trap_req", 32'(trap_req), 0);
        chk(x_suppress == 1'b0, "R1 x_suppress", 32'(x_suppress), 0);
    endtask

    task automatic test_load_err();
        first_err_cycle(1'b0, 32'h0000_1000, 32'h2000_0004);
        chk(trap_req == 1'b0, "R2 no trap in first cycle", 32'(trap_req), 0);
        @(negedge clk);
        dph_ready = 1'b1; dph_err = 1'b1; x_valid = 1'b1; x_side_effect = 1'b1; trap_ack = 1'b1;
        #1;
        chk(trap_req == 1'b1, "R3 trap on second cycle", 32'(trap_req), 1);
        chk(trap_cause == 4'd5, "R4 load cause", 32'(trap_cause), 5);
        chk(trap_pc == 32'h0000_1000, "R5 pc", trap_pc, 32'h0000_1000);
        chk(trap_addr == 32'h2000_0004, "R5 addr", trap_addr, 32'h2000_0004);
        chk(x_suppress == 1'b1, "R10 suppress stage2", 32'(x_suppress), 1);
        idle();
        chk(trap_req == 1'b0, "R9 cleared after ack", 32'(trap_req), 0);
    endtask

    task automatic test_store_err_hold();
        first_err_cycle(1'b1, 32'h0000_2220, 32'h3000_0010);
        idle();
        chk(trap_cause == 4'd7, "R4 store cause", 32'(trap_cause), 7);
        x_valid = 1'b1; x_side_effect = 1'b0; #1;
        chk(x_suppress == 1'b0, "R10 no suppress without side effect", 32'(x_suppress), 0);
        x_valid = 1'b0; x_side_effect = 1'b1; #1;
        chk(x_suppress == 1'b0, "R10 no suppress without valid", 32'(x_suppress), 0);
        for (int i = 0; i < 3; i++) idle();
        chk(trap_req == 1'b1, "R9 held without ack", 32'(trap_req), 1);
        // second error while pending must not overwrite
        first_err_cycle(1'b0, 32'h0000_9990, 32'h4444_0000);
        idle();
        chk(trap_pc == 32'h0000_2220, "R11 pc kept", trap_pc, 32'h0000_2220);
        chk(trap_addr == 32'h3000_0010, "R11 addr kept", trap_addr, 32'h3000_0010);
        chk(trap_cause == 4'd7, "R11 cause kept", 32'(trap_cause), 7);
        trap_ack = 1'b1;
        idle();
        chk(trap_req == 1'b0, "R9 one trap per error", 32'(trap_req), 0);
        idle();
        chk(trap_req == 1'b0, "R9 stays low", 32'(trap_req), 0);
    endtask

    task automatic test_stall_okay();
        @(negedge clk);
        m_valid = 1'b1; m_is_store = 1'b0; dph_ready = 1'b0; dph_err = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk(trap_req == 1'b0, "R6 stall no trap", 32'(trap_req), 0);
        end
        dph_ready = 1'b1;
        idle();
        chk(trap_req == 1'b0, "R7 okay completion", 32'(trap_req), 0);
        // long stall ending in an error still traps
        @(negedge clk);
        m_valid = 1'b1; m_is_store = 1'b1; m_pc = 32'h55; m_addr = 32'h66;
        dph_ready = 1'b0; dph_err = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        dph_err = 1'b1;
        @(negedge clk);
        dph_ready = 1'b1; #1;
        chk(trap_req == 1'b1, "R3 trap after stall", 32'(trap_req), 1);
        chk(trap_addr == 32'h66, "R5 addr after stall", trap_addr, 32'h66);
        trap_ack = 1'b1;
        idle();
    endtask

    task automatic test_ignored();
        @(negedge clk);
        m_valid = 1'b0; dph_ready = 1'b0; dph_err = 1'b1;
        @(negedge clk);
        dph_ready = 1'b1;
        idle();
        chk(trap_req == 1'b0, "R8 error without m_valid", 32'(trap_req), 0);
        @(negedge clk);
        m_valid = 1'b1; dph_ready = 1'b1; dph_err = 1'b1;
        idle();
        chk(trap_req == 1'b0, "R8 lone second error cycle", 32'(trap_req), 0);
    endtask

    initial begin
        #1;
        test_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle();
        test_reset();
        test_load_err();
        test_store_err_hold();
        test_stall_okay();
        test_ignored();
        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule